// File: doc/BRIEF.md
# Software Write-Protection Command Sequencer

This block decodes the stream of byte-load events that a host issues to a page-mode nonvolatile memory. It sits in front of the page write controller and decides, byte by byte, whether a load may reach the page buffer. When software protection is on, a load is only accepted after a three-byte unlock pattern. The same pattern turns protection on the first time it is seen, so protection is global and stays on once set. Longer six-byte patterns turn protection off again or request a full chip erase. Two three-byte commands enter and leave an identification mode, in which fixed manufacturer and device codes are returned.

Every command byte is matched on the low fifteen address bits and the data byte. An unlock opens a page-load window. Each accepted byte restarts the window, and it closes after `WIN_CYC` cycles with no load. A data byte that arrives while protection is on and no window is open is rejected. It starts a lockout of `LOCK_CYC` cycles, during which every byte load is ignored. A byte that breaks a command pattern part way through returns the matcher to idle. That byte is not loaded and causes no lockout.

Top module: `swp_cmd_seq`

## Requirements
- R1: After reset, `prot_on`, `id_mode`, `locked` and `erase_req` are all 0, and `id_rdata` is 0.
- R2: With protection off and no command pattern in progress, a byte load that is not AA at command address 5555h raises `pg_load` in the same cycle as `ld_valid`.
- R3: The loads AA at 5555h, then 55 at 2AAAh, then A0 at 5555h (unlock) set `prot_on` to 1 from the next cycle. None of the three raises `pg_load`. Loads that follow inside the window raise `pg_load`.
- R4: Once the load window has closed (no load for `WIN_CYC` cycles), `prot_on` stays 1 and a plain byte is not loaded.
- R5: A plain byte load while protected with no window open gives `pg_load`=0 and sets `locked` for `LOCK_CYC` cycles. Every byte load during the lockout is ignored, including a complete unlock pattern.
- R6: The loads AA@5555h, 55@2AAAh, 80@5555h, AA@5555h, 55@2AAAh, 20@5555h clear `prot_on`.
- R7: The same six-byte pattern ending in 10@5555h instead gives a one-cycle `erase_req` pulse in the cycle after the last byte, and leaves `prot_on` unchanged.
- R8: AA@5555h, 55@2AAAh, 90@5555h sets `id_mode`. While it is set, `id_rdata` is `MFR_CODE` (BFh) for `rd_addr` 0, `DEV_CODE` (07h) for `rd_addr` 1, and 0 for any other address. The same pattern ending in F0 clears `id_mode`, and `id_rdata` returns to 0.
- R9: A byte that does not fit a command pattern in progress returns the matcher to idle with `pg_load`=0 and no lockout.
- R10: Repeating the unlock while already protected opens one more page-load window, and protection stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | One byte-load event this cycle |
| ld_addr | input | ADDR_W | Address of the byte load |
| ld_data | input | 8 | Data of the byte load |
| rd_addr | input | ADDR_W | Read address used for identification codes |
| pg_load | output | 1 | Current byte load is passed to the page buffer |
| erase_req | output | 1 | One-cycle chip-erase request |
| prot_on | output | 1 | Global software protection state |
| id_mode | output | 1 | Identification mode active |
| locked | output | 1 | Rejected-write lockout running |
| id_rdata | output | 8 | Identification code for `rd_addr` |

## Verification
The bench goes after the cases where a wrong decoder would let data through. If the unlock bytes leak into the page buffer, `pg_load` is seen on a command byte. If protection were tied to a single page, or dropped at window close, a plain byte after the window would be loaded. If the lockout did not gate the matcher, a full unlock sent during the lockout would open a window once the lockout expires. Two more cases are checked. A matcher that locks on a broken pattern, or fails to return to idle after one, shows a spurious `locked` or refuses the unlock that follows. A sequencer that confuses the 10 and 20 final bytes of the six-byte patterns either erases instead of unprotecting or changes `prot_on` during an erase.

// File: rtl/swp_cmd_seq.sv
module swp_cmd_seq #(
  parameter int ADDR_W   = 17,
  parameter int CMD_AW   = 15,
  parameter int LOCK_CYC = 30000,
  parameter int WIN_CYC  = 20000,
  parameter logic [7:0] MFR_CODE = 8'hBF,
  parameter logic [7:0] DEV_CODE = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              pg_load,
  output logic              erase_req,
  output logic              prot_on,
  output logic              id_mode,
  output logic              locked,
  output logic [7:0]        id_rdata
);
  localparam int LCW = $clog2(LOCK_CYC + 1);
  localparam int WCW = $clog2(WIN_CYC + 1);
  localparam logic [CMD_AW-1:0] ADR_A = CMD_AW'(15'h5555);
  localparam logic [CMD_AW-1:0] ADR_B = CMD_AW'(15'h2AAA);

  typedef enum logic [2:0] {S_IDLE, S_C1, S_C2, S_E1, S_E2, S_E3, S_LOAD} st_t;

  st_t            st, st_n;
  logic [LCW-1:0] lock_cnt;
  logic [WCW-1:0] win_cnt;

  wire at_a   = ld_addr[CMD_AW-1:0] == ADR_A;
  wire at_b   = ld_addr[CMD_AW-1:0] == ADR_B;
  wire hit_aa = at_a && ld_data == 8'hAA;
  wire hit_55 = at_b && ld_data == 8'h55;
  wire take   = ld_valid && !locked;
  wire win_end = (st == S_LOAD) && !take && (win_cnt == WCW'(WIN_CYC - 1));

  wire c2_take = take && st == S_C2 && at_a;
  wire e3_take = take && st == S_E3 && at_a;
  wire do_unlock = c2_take && ld_data == 8'hA0;
  wire do_idin   = c2_take && ld_data == 8'h90;
  wire do_idout  = c2_take && ld_data == 8'hF0;
  wire do_unprot = e3_take && ld_data == 8'h20;
  wire do_erase  = e3_take && ld_data == 8'h10;
  wire reject    = take && st == S_IDLE && prot_on && !hit_aa;

  assign locked  = lock_cnt != '0;
  assign pg_load = take && (st == S_LOAD || (st == S_IDLE && !prot_on && !hit_aa));
  assign id_rdata = !id_mode ? 8'h00 :
                    (rd_addr == ADDR_W'(0)) ? MFR_CODE :
                    (rd_addr == ADDR_W'(1)) ? DEV_CODE : 8'h00;

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE: if (take) begin
        if (hit_aa)        st_n = S_C1;
        else if (!prot_on) st_n = S_LOAD;
      end
      S_C1: if (take) st_n = hit_55 ? S_C2 : S_IDLE;
      S_C2: if (take) begin
        if (do_unlock)                     st_n = S_LOAD;
        else if (at_a && ld_data == 8'h80) st_n = S_E1;
        else                               st_n = S_IDLE;
      end
      S_E1: if (take) st_n = hit_aa ? S_E2 : S_IDLE;
      S_E2: if (take) st_n = hit_55 ? S_E3 : S_IDLE;
      S_E3: if (take) st_n = S_IDLE;
      S_LOAD: if (win_end) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      prot_on   <= 1'b0;
      id_mode   <= 1'b0;
      erase_req <= 1'b0;
      lock_cnt  <= '0;
      win_cnt   <= '0;
    end else begin
      st        <= st_n;
      erase_req <= do_erase;
      if (do_unlock)      prot_on <= 1'b1;
      else if (do_unprot) prot_on <= 1'b0;
      if (do_idin)       id_mode <= 1'b1;
      else if (do_idout) id_mode <= 1'b0;
      if (reject)      lock_cnt <= LCW'(LOCK_CYC);
      else if (locked) lock_cnt <= lock_cnt - 1'b1;
      if (take || st != S_LOAD) win_cnt <= '0;
      else                      win_cnt <= win_cnt + 1'b1;
    end
  end

  assert_prot_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(ld_valid) && $past(ld_data) == 8'hA0);
  assert_prot_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(ld_valid) && $past(ld_data) == 8'h20);
  assert_erase_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(ld_valid) && $past(ld_data) == 8'h10 && $stable(prot_on));
  assert_erase_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  assert_lock_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> prot_on && $past(ld_valid));
  assert_id_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(ld_data) == 8'h90);
endmodule

// File: tb/sim_swp_cmd_seq.sv
module sim_swp_cmd_seq;
  localparam int LOCK = 20;
  localparam int WIN  = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ld_valid = 0;
  logic [16:0] ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [16:0] rd_addr = '0;
  logic        pg_load, erase_req, prot_on, id_mode, locked;
  logic [7:0]  id_rdata;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  swp_cmd_seq #(.ADDR_W(17), .CMD_AW(15), .LOCK_CYC(LOCK), .WIN_CYC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_addr(rd_addr), .pg_load(pg_load),
    .erase_req(erase_req), .prot_on(prot_on), .id_mode(id_mode),
    .locked(locked), .id_rdata(id_rdata));

  // {gap, addr, data, expected pg_load, expected prot_on after the byte}
  localparam logic [34:0] VEC [18] = '{
    {8'd2,  17'h00100, 8'h11, 1'b1, 1'b0},
    {8'd0,  17'h00101, 8'h22, 1'b1, 1'b0},
    {8'd12, 17'h05555, 8'hAA, 1'b0, 1'b0},
    {8'd0,  17'h02AAA, 8'h55, 1'b0, 1'b0},
    {8'd0,  17'h05555, 8'hA0, 1'b0, 1'b1},
    {8'd0,  17'h00200, 8'h33, 1'b1, 1'b1},
    {8'd3,  17'h00201, 8'h44, 1'b1, 1'b1},
    {8'd12, 17'h05555, 8'hAA, 1'b0, 1'b1},
    {8'd0,  17'h02AAA, 8'h55, 1'b0, 1'b1},
    {8'd0,  17'h05555, 8'hA0, 1'b0, 1'b1},
    {8'd0,  17'h00300, 8'h55, 1'b1, 1'b1},
    {8'd12, 17'h05555, 8'hAA, 1'b0, 1'b1},
    {8'd0,  17'h02AAA, 8'h55, 1'b0, 1'b1},
    {8'd0,  17'h05555, 8'h80, 1'b0, 1'b1},
    {8'd0,  17'h05555, 8'hAA, 1'b0, 1'b1},
    {8'd0,  17'h02AAA, 8'h55, 1'b0, 1'b1},
    {8'd0,  17'h05555, 8'h20, 1'b0, 1'b0},
    {8'd0,  17'h00400, 8'h66, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [16:0] a, input logic [7:0] d, input logic exp_pg, input string req);
    ld_valid = 1; ld_addr = a; ld_data = d;
    #1 check(req, pg_load, exp_pg);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic cmd3(input logic [7:0] d, input string req);
    send(17'h05555, 8'hAA, 0, req);
    send(17'h02AAA, 8'h55, 0, req);
    send(17'h05555, d, 0, req);
  endtask

  task automatic cmd6(input logic [7:0] d, input string req);
    cmd3(8'h80, req);
    cmd3(d, req);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 prot_on", prot_on, 0);
    check("R1 id_mode", id_mode, 0);
    check("R1 locked", locked, 0);
    check("R1 erase_req", erase_req, 0);
    check("R1 id_rdata", id_rdata, 0);

    // table walk: R2, R3, R10, R6
    foreach (VEC[i]) begin
      idle(int'(VEC[i][34:27]));
      send(VEC[i][26:10], VEC[i][9:2], VEC[i][1], $sformatf("R2/R3/R10/R6 pg vec %0d", i));
      check($sformatf("R3/R6 prot vec %0d", i), prot_on, VEC[i][0]);
    end
    idle(12);

    // R8 identification mode
    cmd3(8'h90, "R8 entry");
    check("R8 id_mode set", id_mode, 1);
    rd_addr = 17'd0; #1 check("R8 mfr code", id_rdata, 8'hBF);
    rd_addr = 17'd1; #1 check("R8 dev code", id_rdata, 8'h07);
    rd_addr = 17'd2; #1 check("R8 other addr", id_rdata, 8'h00);
    idle(1);
    cmd3(8'hF0, "R8 exit");
    check("R8 id_mode clear", id_mode, 0);
    rd_addr = 17'd0; #1 check("R8 code gone", id_rdata, 8'h00);
    idle(1);

    // R7 chip erase
    cmd6(8'h10, "R7 seq");
    check("R7 erase pulse", erase_req, 1);
    check("R7 prot unchanged", prot_on, 0);
    idle(1);
    check("R7 pulse one cycle", erase_req, 0);

    // R9 broken pattern while protected
    cmd3(8'hA0, "R9 unlock");
    check("R9 prot on", prot_on, 1);
    idle(12);
    send(17'h05555, 8'hAA, 0, "R9 first");
    send(17'h02AAA, 8'h12, 0, "R9 break");
    check("R9 no lockout", locked, 0);
    check("R9 prot kept", prot_on, 1);
    cmd3(8'hA0, "R9 relock");
    send(17'h00600, 8'h5A, 1, "R9 idle after break");
    idle(12);

    // R4 / R5 rejection and lockout
    send(17'h00500, 8'h77, 0, "R4 plain byte after window");
    check("R4 prot still on", prot_on, 1);
    check("R5 locked set", locked, 1);
    cmd3(8'hA0, "R5 ignored unlock");
    send(17'h00501, 8'h78, 0, "R5 data during lock");
    check("R5 still locked", locked, 1);
    idle(LOCK);
    check("R5 lock expired", locked, 0);
    send(17'h00502, 8'h79, 0, "R5 no window opened");
    check("R5 relocked", locked, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule